// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters written by a host into an idle-high, non-return-to-zero serial stream. Each character goes first into a one-entry holding buffer. When the shift stage is free, it takes the character and sends it as one frame. The host can therefore write the next character while the current one is still on the line. Back-to-back characters go out with no idle gap between frames.

The frame format is chosen at run time. A frame has one low start bit, then 1 to 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The bit time comes from a 16-bit divisor value B:
- When B is nonzero, one bit lasts (B+1)*8 clocks.
- When B is zero, one bit lasts 16 clocks.

The divisor and the format are sampled when a frame's start bit begins. A change made in the middle of a frame therefore applies only to the next frame.

Two flags report progress. The ready flag says the holding buffer can take a character. The empty flag says that both the buffer and the shifter are idle. Dropping the enable stops output at once: the line is held high and any queued character is discarded.

Top module: `ser_tx`

## Requirements
- R1: After reset, `tx_line`, `buf_ready` and `tx_empty` are all 1. The line is high in every cycle in which `tx_empty` is 1.
- R2: When `baud_sel` is B ≠ 0, every bit of the frame lasts exactly (B+1)*8 clock cycles. The line changes only at bit boundaries.
- R3: When `baud_sel` is 0, every bit lasts exactly 16 clock cycles.
- R4: A character written to an idle, enabled block starts its start bit (line low) after the second rising edge that follows the sampled write strobe. The data bits then follow, least significant bit first. There are `len_m1`+1 data bits, where `len_m1` is 0..7.
- R5: `par_mode` selects the parity bit, which is sent after the data:
  - 2'b01 (odd): the data ones plus the parity bit give an odd total.
  - 2'b10 (even): the total is even.
  - 2'b00 or 2'b11: no parity bit is sent.
  Only the sent data bits count toward parity.
- R6: The frame ends with one high stop bit when `stop2`=0, or two when `stop2`=1. If a character is waiting in the buffer, its start bit begins immediately after the last stop bit, with no idle cycle between frames.
- R7: `buf_ready` rises when the shifter takes the buffered character, which happens at the start bit. This allows a second write while the first frame is still shifting.
- R8: `tx_empty` is 1 only when both the holding buffer and the shifter are empty. It stays 0 for the whole of a frame.
- R9: A write strobe while `buf_ready` is 0 is ignored. It neither replaces the held character nor produces a frame.
- R10: `baud_sel`, `len_m1`, `par_mode` and `stop2` are sampled when a start bit begins. A change in the middle of a frame affects only later frames.
- R11: When `tx_en` is 0 at a rising edge:
  - From the next cycle, the line is high, the partly sent frame is abandoned and the buffer is flushed, so `tx_empty` reads 1.
  - `buf_ready` is 0 while `tx_en` is 0, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| baud_sel | input | 16 | Bit-time divisor B |
| len_m1 | input | 3 | Data length minus one |
| par_mode | input | 2 | Parity select (00/11 none, 01 odd, 10 even) |
| stop2 | input | 1 | 1 = two stop bits |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to write |
| buf_ready | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | Buffer and shifter both empty |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The assertions check the following on every cycle:
- The line is high whenever the block is empty.
- The line changes only on a bit tick or a frame load.
- A load is always followed by a low start bit.
- A rise of the ready flag while enabled coincides with a start bit.
- The held character never changes while the buffer is not ready.
- Disabling returns the line high and the block to empty.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle of each frame against a waveform built from the requirements:
- The exact bit length for zero and nonzero divisors.
- Least-significant-bit-first order and parity values.
- The stop-bit count and gapless back-to-back frames.
- A format change in mid-frame applying only to the next frame.
- Discarded writes, which are shown by the absence of any later frame.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE     = 2'b00,
      PAR_ODD      = 2'b01,
      PAR_EVEN     = 2'b10,
      PAR_NONE_ALT = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_e;

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
   parameter int BAUD_W     = 16,
   parameter int OVERSAMPLE = 8,
   parameter int ZERO_DIV   = 16,
   parameter int PER_W      = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic [BAUD_W-1:0] baud_sel,
   output logic              tick
);
   localparam int OS_SH = $clog2(OVERSAMPLE);

   initial begin
      assert (BAUD_W >= 1) else $error("BAUD_W must be at least 1");
      assert (OVERSAMPLE >= 2) else $error("OVERSAMPLE must be at least 2");
      assert (ZERO_DIV >= 2) else $error("ZERO_DIV must be at least 2");
      assert (PER_W >= BAUD_W + OS_SH + 1) else $error("PER_W too narrow");
   end

   logic [PER_W-1:0] ext_plus1;
   logic [PER_W-1:0] scaled;
   logic [PER_W-1:0] per_d;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;

   assign ext_plus1 = {{(PER_W-BAUD_W){1'b0}}, baud_sel} + PER_W'(1);

   if ((1 << OS_SH) == OVERSAMPLE) begin : g_shift
      assign scaled = ext_plus1 << OS_SH;
   end else begin : g_mul
      assign scaled = ext_plus1 * PER_W'(OVERSAMPLE);
   end

   assign per_d = (baud_sel == '0) ? PER_W'(ZERO_DIV) : scaled;
   assign tick  = run && (cnt_q == per_q - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= PER_W'(ZERO_DIV);
         cnt_q <= '0;
      end else if (restart) begin
         per_q <= per_d;
         cnt_q <= '0;
      end else if (run) begin
         if (tick) cnt_q <= '0;
         else      cnt_q <= cnt_q + PER_W'(1);
      end else begin
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data_q
);
   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
   end

   logic full_q;
   logic accept;

   assign accept = tx_en && wr_valid && !full_q;
   assign full   = full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (!tx_en) begin
         full_q <= 1'b0;
      end else if (accept) begin
         full_q <= 1'b1;
         data_q <= wr_data;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
   import ser_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [1:0]        par_mode,
   input  logic              stop2,
   input  logic              tick,
   output logic              load,
   output logic              busy,
   output logic              line
);
   initial begin
      assert (DATA_W == (1 << LEN_W)) else $error("DATA_W must be 2**LEN_W");
   end

   tx_state_e         state_q;
   logic [DATA_W-1:0] shreg_q;
   logic [LEN_W-1:0]  idx_q;
   logic [LEN_W-1:0]  len_q;
   logic              par_en_q;
   logic              par_bit_q;
   logic              stop2_q;
   logic              stop_left_q;

   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] masked;
   logic              ones_odd;
   logic              frame_end;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep_mask[i] = (LEN_W'(i) <= len_m1);
   end

   assign masked    = hold_data & keep_mask;
   assign ones_odd  = ^masked;
   assign frame_end = (state_q == ST_STOP) && tick && !stop_left_q;
   assign load      = tx_en && hold_full && ((state_q == ST_IDLE) || frame_end);
   assign busy      = (state_q != ST_IDLE);

   always_comb begin
      case (state_q)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg_q[0];
         ST_PAR:   line = par_bit_q;
         default:  line = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         shreg_q     <= '0;
         idx_q       <= '0;
         len_q       <= '0;
         par_en_q    <= 1'b0;
         par_bit_q   <= 1'b0;
         stop2_q     <= 1'b0;
         stop_left_q <= 1'b0;
      end else if (!tx_en) begin
         state_q <= ST_IDLE;
      end else if (load) begin
         state_q   <= ST_START;
         shreg_q   <= masked;
         idx_q     <= '0;
         len_q     <= len_m1;
         par_en_q  <= (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
         par_bit_q <= (par_mode == PAR_ODD) ? ~ones_odd : ones_odd;
         stop2_q   <= stop2;
      end else if (tick) begin
         case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
               shreg_q <= shreg_q >> 1;
               if (idx_q == len_q) begin
                  stop_left_q <= stop2_q;
                  state_q     <= par_en_q ? ST_PAR : ST_STOP;
               end else begin
                  idx_q <= idx_q + LEN_W'(1);
               end
            end
            ST_PAR: begin
               stop_left_q <= stop2_q;
               state_q     <= ST_STOP;
            end
            ST_STOP: begin
               if (stop_left_q) stop_left_q <= 1'b0;
               else             state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
   parameter int BAUD_W     = 16,
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 8,
   parameter int ZERO_DIV   = 16,
   localparam int LEN_W     = $clog2(DATA_W),
   localparam int PER_W     = BAUD_W + $clog2(OVERSAMPLE) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [BAUD_W-1:0] baud_sel,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [1:0]        par_mode,
   input  logic              stop2,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              buf_ready,
   output logic              tx_empty,
   output logic              tx_line
);
   logic              hold_full_w;
   logic [DATA_W-1:0] hold_data_w;
   logic              load_w;
   logic              busy_w;
   logic              tick_w;

   ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .take     (load_w),
      .full     (hold_full_w),
      .data_q   (hold_data_w)
   );

   ser_tx_baud #(
      .BAUD_W     (BAUD_W),
      .OVERSAMPLE (OVERSAMPLE),
      .ZERO_DIV   (ZERO_DIV),
      .PER_W      (PER_W)
   ) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (load_w),
      .run      (busy_w),
      .baud_sel (baud_sel),
      .tick     (tick_w)
   );

   ser_tx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .hold_full (hold_full_w),
      .hold_data (hold_data_w),
      .len_m1    (len_m1),
      .par_mode  (par_mode),
      .stop2     (stop2),
      .tick      (tick_w),
      .load      (load_w),
      .busy      (busy_w),
      .line      (tx_line)
   );

   assign buf_ready = tx_en && !hold_full_w;
   assign tx_empty  = !hold_full_w && !busy_w;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              buf_ready,
   input logic              tx_empty,
   input logic              tx_line,
   input logic              load,
   input logic              tick,
   input logic [DATA_W-1:0] hold_data
);
   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_line); // R1

   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && !$past(tick) && !$past(load)) |-> $stable(tx_line)); // R2

   AST_LOAD_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx_line); // R4

   AST_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && $rose(buf_ready)) |-> !tx_line); // R7

   AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && tx_en) |-> buf_ready); // R8

   AST_REJECT_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !buf_ready) |=> $stable(hold_data)); // R9

   AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (tx_line && tx_empty)); // R11
endmodule

bind ser_tx ser_tx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .buf_ready (buf_ready),
   .tx_empty  (tx_empty),
   .tx_line   (tx_line),
   .load      (load_w),
   .tick      (tick_w),
   .hold_data (hold_data_w)
);

// File: tb/ser_tx_test.sv
`timescale 1ns/1ps
module ser_tx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b1;
   logic [15:0] baud_sel = 16'd0;
   logic [2:0]  len_m1 = 3'd7;
   logic [1:0]  par_mode = 2'b00;
   logic        stop2 = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        buf_ready;
   logic        tx_empty;
   logic        tx_line;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic eb [0:31];
   int   ep [0:31];
   int   en = 0;

   int          act1_at = -1;
   logic [7:0]  act1_d  = 8'h00;
   int          act2_at = -1;
   logic [7:0]  act2_d  = 8'h00;
   logic        rdy_at_act2 = 1'b0;
   int          cfg_at = -1;
   logic [15:0] nb_baud = 16'd0;
   logic [2:0]  nb_len = 3'd7;
   logic [1:0]  nb_par = 2'b00;
   logic        nb_stop = 1'b0;

   always #2.5 clk = ~clk;

   ser_tx uut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_sel(baud_sel),
      .len_m1(len_m1), .par_mode(par_mode), .stop2(stop2),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .buf_ready(buf_ready), .tx_empty(tx_empty), .tx_line(tx_line)
   );

   task automatic check(input string req, input string what, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic add_frame(input logic [7:0] d, input int lm1, input logic [1:0] pm,
                            input logic s2, input int b);
      int p;
      logic par;
      p = (b == 0) ? 16 : (b + 1) * 8;
      par = 1'b0;
      eb[en] = 1'b0; ep[en] = p; en++;
      for (int i = 0; i <= lm1; i++) begin
         eb[en] = d[i]; ep[en] = p; en++;
         par = par ^ d[i];
      end
      if (pm == 2'b01) begin eb[en] = ~par; ep[en] = p; en++; end
      if (pm == 2'b10) begin eb[en] = par;  ep[en] = p; en++; end
      eb[en] = 1'b1; ep[en] = p; en++;
      if (s2) begin eb[en] = 1'b1; ep[en] = p; en++; end
   endtask

   task automatic set_cfg(input int b, input int l, input logic [1:0] p, input logic s);
      @(negedge clk);
      baud_sel = 16'(b); len_m1 = 3'(l); par_mode = p; stop2 = s;
   endtask

   // returns at the negedge where the line is first seen low
   task automatic start_write(input logic [7:0] d, output int lat);
      wr_valid = 1'b1; wr_data = d; lat = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         lat++;
         wr_valid = 1'b0;
         if (!tx_line) break;
      end
   endtask

   task automatic run_wave(input string req, input bit expect_idle_after);
      int k, mism, emp;
      k = 0; mism = 0; emp = 0;
      for (int b = 0; b < en; b++) begin
         for (int c = 0; c < ep[b]; c++) begin
            if (k > 0) @(negedge clk);
            if (tx_line !== eb[b]) mism++;
            if (tx_empty) emp++;
            if (k == act1_at) begin
               wr_valid = 1'b1; wr_data = act1_d;
            end else if (k == act2_at) begin
               rdy_at_act2 = buf_ready; wr_valid = 1'b1; wr_data = act2_d;
            end else begin
               wr_valid = 1'b0;
            end
            if (k == cfg_at) begin
               baud_sel = nb_baud; len_m1 = nb_len; par_mode = nb_par; stop2 = nb_stop;
            end
            k++;
         end
      end
      check(req, "frame waveform mismatching cycles", mism, 0);
      check("R8", "cycles with tx_empty high inside a frame", emp, 0);
      @(negedge clk);
      wr_valid = 1'b0;
      if (expect_idle_after) begin
         check("R6", "line high after last stop", int'(tx_line), 1);
         check("R8", "tx_empty after frame", int'(tx_empty), 1);
      end
      act1_at = -1; act2_at = -1; cfg_at = -1; en = 0;
   endtask

   task automatic t_reset();
      check("R1", "tx_line after reset", int'(tx_line), 1);
      check("R1", "buf_ready after reset", int'(buf_ready), 1);
      check("R1", "tx_empty after reset", int'(tx_empty), 1);
   endtask

   task automatic t_basic();
      int lat;
      set_cfg(2, 7, 2'b00, 1'b0);
      add_frame(8'hA5, 7, 2'b00, 1'b0, 2);
      start_write(8'hA5, lat);
      check("R4", "negedges from write to start bit", lat, 2);
      run_wave("R2", 1'b1);
      set_cfg(300, 7, 2'b00, 1'b0);
      add_frame(8'h6E, 7, 2'b00, 1'b0, 300);
      start_write(8'h6E, lat);
      run_wave("R2", 1'b1);
   endtask

   task automatic t_zero_div();
      int lat;
      set_cfg(0, 7, 2'b00, 1'b0);
      add_frame(8'h3C, 7, 2'b00, 1'b0, 0);
      start_write(8'h3C, lat);
      run_wave("R3", 1'b1);
      set_cfg(1, 7, 2'b00, 1'b0);
      add_frame(8'hC1, 7, 2'b00, 1'b0, 1);
      start_write(8'hC1, lat);
      run_wave("R3", 1'b1);
   endtask

   task automatic t_parity();
      int lat;
      set_cfg(1, 7, 2'b01, 1'b0);
      add_frame(8'h03, 7, 2'b01, 1'b0, 1);
      start_write(8'h03, lat);
      run_wave("R5", 1'b1);
      set_cfg(1, 4, 2'b10, 1'b0);
      add_frame(8'hF7, 4, 2'b10, 1'b0, 1);
      start_write(8'hF7, lat);
      run_wave("R5", 1'b1);
      set_cfg(1, 6, 2'b10, 1'b0);
      add_frame(8'h81, 6, 2'b10, 1'b0, 1);
      start_write(8'h81, lat);
      run_wave("R5", 1'b1);
      set_cfg(1, 7, 2'b11, 1'b0);
      add_frame(8'h96, 7, 2'b11, 1'b0, 1);
      start_write(8'h96, lat);
      run_wave("R5", 1'b1);
   endtask

   task automatic t_stop2_len1();
      int lat;
      set_cfg(3, 0, 2'b01, 1'b1);
      add_frame(8'hFF, 0, 2'b01, 1'b1, 3);
      start_write(8'hFF, lat);
      run_wave("R6", 1'b1);
      set_cfg(3, 0, 2'b00, 1'b1);
      add_frame(8'h00, 0, 2'b00, 1'b1, 3);
      start_write(8'h00, lat);
      run_wave("R4", 1'b1);
   endtask

   task automatic t_double();
      int lat, lows;
      set_cfg(1, 7, 2'b00, 1'b0);
      add_frame(8'h5A, 7, 2'b00, 1'b0, 1);
      add_frame(8'hC3, 7, 2'b00, 1'b0, 1);
      start_write(8'h5A, lat);
      check("R7", "buf_ready at first start bit", int'(buf_ready), 1);
      check("R8", "tx_empty at first start bit", int'(tx_empty), 0);
      act1_at = 0;  act1_d = 8'hC3;
      act2_at = 48; act2_d = 8'h0F;
      run_wave("R6", 1'b1);
      check("R9", "buf_ready when extra write issued", int'(rdy_at_act2), 0);
      lows = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!tx_line || !tx_empty) lows++;
      end
      check("R9", "activity after ignored write", lows, 0);
   endtask

   task automatic t_fmt_change();
      int lat;
      set_cfg(2, 7, 2'b00, 1'b0);
      add_frame(8'h96, 7, 2'b00, 1'b0, 2);
      start_write(8'h96, lat);
      cfg_at = 30; nb_baud = 16'd4; nb_len = 3'd3; nb_par = 2'b10; nb_stop = 1'b1;
      run_wave("R10", 1'b1);
      add_frame(8'h96, 3, 2'b10, 1'b1, 4);
      start_write(8'h96, lat);
      run_wave("R10", 1'b1);
   endtask

   task automatic t_disable();
      int lat, lows;
      set_cfg(5, 7, 2'b00, 1'b0);
      start_write(8'h00, lat);
      repeat (60) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      check("R11", "line after disable", int'(tx_line), 1);
      check("R11", "buf_ready while disabled", int'(buf_ready), 0);
      check("R11", "tx_empty after disable", int'(tx_empty), 1);
      wr_valid = 1'b1; wr_data = 8'h55;
      @(negedge clk);
      wr_valid = 1'b0;
      tx_en = 1'b1;
      @(negedge clk);
      check("R11", "buf_ready after re-enable", int'(buf_ready), 1);
      lows = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!tx_line || !tx_empty) lows++;
      end
      check("R11", "activity after disabled write", lows, 0);
      add_frame(8'h81, 7, 2'b00, 1'b0, 5);
      start_write(8'h81, lat);
      run_wave("R11", 1'b1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_zero_div();
      t_parity();
      t_stop2_len1();
      t_double();
      t_fmt_change();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule